// File: doc/BRIEF.md
# RS-485 RTU Transmit Framer

This block turns a single send request into a complete RTU frame on a byte-wide UART transmit interface. A request carries a unit address, a function code and a payload length. The payload bytes sit in a small external buffer that the block reads by index. The block emits the address, then the function code, then the payload, and then a 16-bit CRC that it computes as the bytes leave.

Around each frame the block also steers an RS-485 transceiver. It first turns the local receiver off, then turns the line driver on, and only then presents the first byte. After the final CRC byte has been taken, it keeps the driver on until the UART reports that the last stop bit has left the shifter. It then drops the driver and turns the receiver back on, with a one-cycle pulse that marks the line as handed back. While a frame is in progress the block reports busy, and it discards any new request.

Top module: `rtu_tx_framer`

## Requirements
- R1: A frame with payload length L is exactly L+4 bytes in this order: address, function code, payload bytes 0 to L-1 (read through `pay_idx`), CRC low byte, CRC high byte.
- R2: The CRC starts at 0xFFFF and covers only the address, function code and payload. For each byte, the byte is XORed into bits 7:0. Eight steps follow, each a right shift by one, and when the bit shifted out is 1 the register is then XORed with 0xA001.
- R3: The CRC low byte (bits 7:0) is sent before the high byte (bits 15:8).
- R4: A request is taken when `req_valid` is high and `busy` is low. In the next cycle `busy` is 1 and both `rcv_en` and `drv_en` are 0. One cycle later `drv_en` is 1. In the cycle after that, `uart_tx_valid` is first high.
- R5: After the last byte handshake, `drv_en` stays 1 until `uart_tx_done` is sampled high. `drv_en` is 0 in the next cycle, while `rcv_en` is still 0. One cycle after that, `rcv_en` is 1 and `line_released` pulses high for one cycle.
- R6: `busy` is high from the cycle after acceptance until the cycle in which `rcv_en` returns to 1. A request made while `busy` is high produces no bytes.
- R7: Payload lengths from 0 to 252 are sent as given. A requested length above 252 is sent as 252.
- R8: While `uart_tx_valid` is high and `uart_tx_ready` is low, the valid signal and `uart_tx_data` hold their values into the next cycle.
- R9: After reset, `rcv_en` is 1, and `drv_en`, `busy`, `uart_tx_valid` and `line_released` are 0.
- R10: `drv_en` and `rcv_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Send request |
| req_addr | input | 8 | Unit address of the frame |
| req_func | input | 8 | Function code of the frame |
| req_len | input | LEN_W (8) | Payload length in bytes |
| pay_idx | output | LEN_W (8) | Payload buffer read index |
| pay_data | input | 8 | Payload byte at `pay_idx` (combinational read) |
| uart_tx_valid | output | 1 | Byte offered to the UART |
| uart_tx_data | output | 8 | Offered byte |
| uart_tx_ready | input | 1 | UART accepts the offered byte |
| uart_tx_done | input | 1 | UART has fully shifted out everything it accepted |
| drv_en | output | 1 | RS-485 driver enable |
| rcv_en | output | 1 | RS-485 receiver enable |
| busy | output | 1 | Frame in progress |
| line_released | output | 1 | One-cycle pulse when the receiver is turned back on |

## Verification
A wrong byte counter shows up at once as a missing, repeated or misplaced byte in the captured stream. A fault in the CRC register only shows up at the two closing bytes, after the whole payload, so every frame length from zero upward is compared byte by byte against a CRC that the bench works out itself. A fault in the direction state shows up on `drv_en` and `rcv_en` in the first cycles after a request, and again at the end of the frame. The end of the frame is the subtle case: dropping the driver one cycle before the UART reports done would cut off the last stop bit. So the bench drives a UART model whose done signal lags each accepted byte, and it checks every edge of the two enables against that signal.

// File: rtl/rtu_tx_pkg.sv
package rtu_tx_pkg;

    localparam logic [15:0] CRC_SEED = 16'hFFFF;
    localparam logic [15:0] CRC_POLY = 16'hA001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX_OFF,
        ST_DRV_ON,
        ST_SEND,
        ST_DRAIN,
        ST_DRV_OFF
    } dir_state_e;

    typedef enum logic [2:0] {
        SRC_ADDR,
        SRC_FUNC,
        SRC_PAYLOAD,
        SRC_CRC_LO,
        SRC_CRC_HI
    } byte_src_e;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] func;
    } frame_hdr_t;

    function automatic logic [15:0] crc16_fold(input logic [15:0] cur,
                                               input logic [7:0]  din,
                                               input logic [15:0] poly);
        logic [15:0] r;
        r = cur ^ {8'h00, din};
        for (int b = 0; b < 8; b++) begin
            if (r[0]) r = (r >> 1) ^ poly;
            else      r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rtu_crc16_acc.sv
module rtu_crc16_acc
    import rtu_tx_pkg::*;
#(
    parameter logic [15:0] SEED = CRC_SEED,
    parameter logic [15:0] POLY = CRC_POLY
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            crc <= SEED;
        end else if (en) begin
            crc <= crc16_fold(crc, din, POLY);
        end
    end

endmodule

// File: rtl/rtu_byte_seq.sv
module rtu_byte_seq
    import rtu_tx_pkg::*;
#(
    parameter int MAX_PAYLOAD = 252,
    localparam int LEN_W = $clog2(MAX_PAYLOAD + 1),
    localparam int IDX_W = $clog2(MAX_PAYLOAD + 4)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  frame_hdr_t       hdr_in,
    input  logic [LEN_W-1:0] len_in,
    input  logic             advance,
    input  logic [15:0]      crc_in,
    input  logic [7:0]       pay_data,
    output logic [LEN_W-1:0] pay_idx,
    output logic [7:0]       byte_out,
    output logic             is_data,
    output logic             is_last
);

    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_PAYLOAD);

    frame_hdr_t       hdr_q;
    logic [LEN_W-1:0] len_q;
    logic [IDX_W-1:0] idx_q;
    byte_src_e        src;

    logic [IDX_W:0] idx_x;
    logic [IDX_W:0] crc_lo_pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q <= '0;
            len_q <= '0;
            idx_q <= '0;
        end else if (start) begin
            hdr_q <= hdr_in;
            len_q <= (len_in > LEN_CAP) ? LEN_CAP : len_in;
            idx_q <= '0;
        end else if (advance) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign idx_x      = {1'b0, idx_q};
    assign crc_lo_pos = (IDX_W + 1)'(len_q) + (IDX_W + 1)'(2);

    always_comb begin
        if (idx_x == '0)                   src = SRC_ADDR;
        else if (idx_x == (IDX_W + 1)'(1)) src = SRC_FUNC;
        else if (idx_x < crc_lo_pos)       src = SRC_PAYLOAD;
        else if (idx_x == crc_lo_pos)      src = SRC_CRC_LO;
        else                               src = SRC_CRC_HI;
    end

    assign pay_idx = LEN_W'(idx_q - IDX_W'(2));

    always_comb begin
        unique case (src)
            SRC_ADDR:    byte_out = hdr_q.addr;
            SRC_FUNC:    byte_out = hdr_q.func;
            SRC_PAYLOAD: byte_out = pay_data;
            SRC_CRC_LO:  byte_out = crc_in[7:0];
            default:     byte_out = crc_in[15:8];
        endcase
    end

    assign is_data = (src == SRC_ADDR) || (src == SRC_FUNC) || (src == SRC_PAYLOAD);
    assign is_last = (src == SRC_CRC_HI);

endmodule

// File: rtl/rtu_dir_ctrl.sv
module rtu_dir_ctrl
    import rtu_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       last_accept,
    input  logic       tx_done,
    output dir_state_e state,
    output logic       start,
    output logic       drv_en,
    output logic       rcv_en,
    output logic       busy,
    output logic       released
);

    dir_state_e nxt;

    assign start = req && (state == ST_IDLE);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_RX_OFF;
            ST_RX_OFF:  nxt = ST_DRV_ON;
            ST_DRV_ON:  nxt = ST_SEND;
            ST_SEND:    if (last_accept) nxt = ST_DRAIN;
            ST_DRAIN:   if (tx_done) nxt = ST_DRV_OFF;
            ST_DRV_OFF: nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            released <= 1'b0;
        end else begin
            state    <= nxt;
            released <= (state == ST_DRV_OFF);
        end
    end

    assign drv_en = (state == ST_DRV_ON) || (state == ST_SEND) || (state == ST_DRAIN);
    assign rcv_en = (state == ST_IDLE);
    assign busy   = (state != ST_IDLE);

endmodule

// File: rtl/rtu_tx_framer.sv
module rtu_tx_framer
    import rtu_tx_pkg::*;
#(
    parameter int MAX_PAYLOAD = 252,
    localparam int LEN_W = $clog2(MAX_PAYLOAD + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [7:0]       req_addr,
    input  logic [7:0]       req_func,
    input  logic [LEN_W-1:0] req_len,
    output logic [LEN_W-1:0] pay_idx,
    input  logic [7:0]       pay_data,
    output logic             uart_tx_valid,
    output logic [7:0]       uart_tx_data,
    input  logic             uart_tx_ready,
    input  logic             uart_tx_done,
    output logic             drv_en,
    output logic             rcv_en,
    output logic             busy,
    output logic             line_released
);

    dir_state_e  state;
    logic        start;
    logic        advance;
    logic        is_data;
    logic        is_last;
    logic [15:0] crc;
    frame_hdr_t  hdr;

    assign hdr.addr = req_addr;
    assign hdr.func = req_func;

    assign uart_tx_valid = (state == ST_SEND);
    assign advance       = uart_tx_valid && uart_tx_ready;

    rtu_dir_ctrl u_dir (
        .clk        (clk),
        .rst        (rst),
        .req        (req_valid),
        .last_accept(advance && is_last),
        .tx_done    (uart_tx_done),
        .state      (state),
        .start      (start),
        .drv_en     (drv_en),
        .rcv_en     (rcv_en),
        .busy       (busy),
        .released   (line_released)
    );

    rtu_byte_seq #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .hdr_in  (hdr),
        .len_in  (req_len),
        .advance (advance),
        .crc_in  (crc),
        .pay_data(pay_data),
        .pay_idx (pay_idx),
        .byte_out(uart_tx_data),
        .is_data (is_data),
        .is_last (is_last)
    );

    rtu_crc16_acc u_crc (
        .clk (clk),
        .rst (rst),
        .init(start),
        .en  (advance && is_data),
        .din (uart_tx_data),
        .crc (crc)
    );

endmodule

// File: rtl/rtu_tx_framer_chk.sv
module rtu_tx_framer_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       uart_tx_valid,
    input logic [7:0] uart_tx_data,
    input logic       uart_tx_ready,
    input logic       uart_tx_done,
    input logic       drv_en,
    input logic       rcv_en,
    input logic       busy,
    input logic       line_released
);

    a_r10_dir_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(drv_en && rcv_en));

    a_r4_valid_needs_driver: assert property (@(posedge clk) disable iff (rst)
        uart_tx_valid |-> (drv_en && !rcv_en));

    a_r4_accept_rx_off: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> (busy && !rcv_en && !drv_en));

    a_r5_driver_waits_done: assert property (@(posedge clk) disable iff (rst)
        $fell(drv_en) |-> $past(uart_tx_done));

    a_r5_rcv_after_driver: assert property (@(posedge clk) disable iff (rst)
        $rose(rcv_en) |-> (!$past(drv_en) && line_released));

    a_r8_hold_offer: assert property (@(posedge clk) disable iff (rst)
        (uart_tx_valid && !uart_tx_ready) |=> (uart_tx_valid && $stable(uart_tx_data)));

endmodule

bind rtu_tx_framer rtu_tx_framer_chk u_chk (.*);

// File: tb/rtu_tx_framer_test.sv
module rtu_tx_framer_test;

    localparam int SHIFT = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_func = '0;
    logic [7:0] req_len = '0;
    logic [7:0] pay_idx;
    logic [7:0] pay_data;
    logic       uart_tx_valid;
    logic [7:0] uart_tx_data;
    logic       uart_tx_ready = 1'b1;
    logic       uart_tx_done = 1'b1;
    logic       drv_en, rcv_en, busy, line_released;

    logic [7:0] pay_mem [256];
    logic [7:0] cap [300];
    logic [7:0] exp_b [300];
    int  cap_cnt = 0;
    int  tests = 0;
    int  fails = 0;
    int  cycles = 0;
    int  sh_cnt = 0;
    bit  ready_mode = 1'b0;
    logic [7:0] lfsr = 8'h5A;
    logic prev_valid = 0, prev_ready = 0, prev_drv = 0, prev_done = 1;
    logic [7:0] prev_data = '0;

    always #4 clk = ~clk;

    assign pay_data = pay_mem[pay_idx];

    rtu_tx_framer uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {8'h00, exp_b[i]};
            for (int k = 0; k < 8; k++) begin
                if (c[0]) c = {1'b0, c[15:1]} ^ 16'hA001;
                else      c = {1'b0, c[15:1]};
            end
        end
        return c;
    endfunction

    // monitor and UART model, all at the falling edge
    always @(negedge clk) begin
        logic rdy;
        if (!rst) begin
            if (prev_drv && !drv_en)
                chk(prev_done, "R5 driver dropped before done", 0, 1);
            if (prev_valid && !prev_ready)
                chk(uart_tx_valid && uart_tx_data == prev_data, "R8 offer held", uart_tx_data, prev_data);
            chk(!(drv_en && rcv_en), "R10 enables exclusive", {drv_en, rcv_en}, 0);
        end
        if (ready_mode) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            rdy = lfsr[0] | lfsr[2];
        end else begin
            rdy = 1'b1;
        end
        uart_tx_ready = rdy;
        if (!rst && uart_tx_valid && rdy) begin
            if (cap_cnt < 300) cap[cap_cnt] = uart_tx_data;
            cap_cnt++;
            uart_tx_done = 1'b0;
            sh_cnt = SHIFT;
        end else if (sh_cnt > 0) begin
            sh_cnt--;
            if (sh_cnt == 0) uart_tx_done = 1'b1;
        end
        prev_valid = uart_tx_valid;
        prev_ready = rdy;
        prev_data  = uart_tx_data;
        prev_drv   = drv_en;
        prev_done  = uart_tx_done;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic send_frame(input logic [7:0] a, input logic [7:0] f, input int len,
                              input bit mode, input bit poke);
        int  eff;
        int  wait_n;
        int  held;
        logic [15:0] c;
        eff = (len > 252) ? 252 : len;
        ready_mode = mode;
        for (int i = 0; i < 256; i++) pay_mem[i] = 8'((i * 29 + a + len) & 255);
        exp_b[0] = a;
        exp_b[1] = f;
        for (int i = 0; i < eff; i++) exp_b[2 + i] = pay_mem[i];
        c = ref_crc(eff + 2);
        exp_b[eff + 2] = c[7:0];
        exp_b[eff + 3] = c[15:8];
        cap_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_func = f; req_len = 8'(len);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy && !rcv_en && !drv_en && !uart_tx_valid, "R4 receiver off first",
            {busy, rcv_en, drv_en, uart_tx_valid}, 4'b1000);
        @(negedge clk);
        chk(drv_en && !rcv_en && !uart_tx_valid, "R4 driver on before data",
            {drv_en, rcv_en, uart_tx_valid}, 3'b100);
        @(negedge clk);
        chk(uart_tx_valid == 1'b1, "R4 first offer", uart_tx_valid, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            req_valid = 1'b1; req_len = 8'd1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        wait_n = 0;
        while (!line_released && wait_n < 5000) begin
            @(negedge clk);
            chk(busy == !rcv_en, "R6 busy tracks receiver", busy, !rcv_en);
            wait_n++;
        end
        chk(line_released && rcv_en && !drv_en && !busy, "R5 line handed back",
            {line_released, rcv_en, drv_en, busy}, 4'b1100);
        chk(cap_cnt == eff + 4, (len > 252) ? "R7 clamped length" : "R1 byte count",
            cap_cnt, eff + 4);
        for (int i = 0; i < eff + 2 && i < cap_cnt; i++)
            chk(cap[i] == exp_b[i], "R1 frame byte", cap[i], exp_b[i]);
        if (cap_cnt >= eff + 4) begin
            chk(cap[eff + 2] == exp_b[eff + 2], "R2 R3 crc low first", cap[eff + 2], exp_b[eff + 2]);
            chk(cap[eff + 3] == exp_b[eff + 3], "R2 R3 crc high second", cap[eff + 3], exp_b[eff + 3]);
        end
        @(negedge clk);
        chk(!line_released, "R5 release is a pulse", line_released, 0);
        held = cap_cnt;
        repeat (10) @(negedge clk);
        chk(cap_cnt == held && !busy && !uart_tx_valid, "R6 busy request ignored",
            cap_cnt, held);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rcv_en && !drv_en && !busy && !uart_tx_valid && !line_released,
            "R9 reset state", {rcv_en, drv_en, busy, uart_tx_valid, line_released}, 5'b10000);
        for (int m = 0; m < 2; m++)
            for (int l = 0; l <= 8; l++)
                send_frame(8'(17 * l + 1), 8'(3 + m), l, m[0], l == 5);
        send_frame(8'hF7, 8'h10, 252, 1'b1, 1'b1);
        send_frame(8'h01, 8'h03, 255, 1'b0, 1'b0);
        send_frame(8'h00, 8'hFF, 253, 1'b1, 1'b0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule